// File: doc/BRIEF.md
# Contact Image Sensor Readout Sequencer

This block produces the digital drive for a chain of cascaded linear contact image sensor dies. It derives a 50% duty sensor clock from the system clock, issues the start pulse that opens every line, and drives the level of the resolution-select pin. Full resolution gives the whole active pixel count of each die. Half resolution gives half that count, because the sensor sums adjacent pixel pairs. Analog video capture is left to the surrounding logic. That logic uses the sequencer's valid flag and its die and pixel indices to decide which samples to keep.

One line is a whole number of sensor clock cycles. Each sensor cycle carries two pixels, one per half period. The stream opens with a fixed run of inactive pixels that only the first die emits. The active pixels of every die follow back to back, and padding fills out the rest of the line. The programmed line period, which sets the integration time, is stretched whenever it would end before the readout is complete. A sticky flag records that this has happened. New settings for mode, die count, divider and period are taken only when a line starts.

Top module: `cis_readout_seq`

## Requirements
- R1: While a line runs, the sensor clock is low for the first half period of every sensor cycle and high for the second. Each half period lasts the latched divider value in system cycles. The sensor clock is low while idle.
- R2: The divider input is clamped to the range HALF_MIN..HALF_MAX before use. HALF_MIN is ceil(SYS_HZ/3 MHz) and HALF_MAX is floor(SYS_HZ/500 kHz), so the pixel rate SYS_HZ/half stays within 500 kHz to 3 MHz.
- R3: The start pulse is high for exactly the first sensor cycle (two half periods) of each line, so one rising edge of the sensor clock falls inside it.
- R4: With mode input 1 (full resolution) each die has ACT_FULL active pixels and the mode pin is driven high. With mode input 0 (half resolution) each die has ACT_FULL/2 active pixels and the mode pin is driven low. After reset the mode pin is low.
- R5: Half period number h of a line (counting from 0) carries pixel position h. The valid flag is high exactly for h in INACTIVE .. INACTIVE+active*dies-1. While it is high, the die index is (h-INACTIVE)/active and the pixel index is (h-INACTIVE) mod active. Both indices read 0 whenever the flag is low.
- R6: A die count of 0 is treated as 1, and a count above MAX_DIES is treated as MAX_DIES.
- R7: A line lasts max(period, ceil((INACTIVE + active*dies)/2)) sensor cycles, where period is the programmed line period in sensor cycles. The half periods after the last active pixel are padding.
- R8: The clamp flag is set when a line starts with a programmed period below the minimum. It stays set until reset.
- R9: The line-done output pulses for one system cycle, the last cycle of each line. If enable is high in that cycle, the next line starts on the following cycle.
- R10: Changes to mode, die count, divider or period during a line have no effect until the next line starts.
- R11: When enable is low at the end of a line, the sequencer goes idle. It starts a fresh line on the first cycle in which enable is sampled high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run lines continuously while high |
| mode_full | input | 1 | 1 selects full resolution, 0 selects half resolution |
| die_count | input | DIE_W | Number of cascaded dies |
| half_div | input | DIV_W | Sensor clock half period in system cycles |
| line_period | input | PER_W | Requested line period in sensor cycles |
| sensor_start | output | 1 | Start pulse to the first die |
| sensor_clk | output | 1 | Sensor clock |
| mode_pin | output | 1 | Resolution-select pin level |
| pix_valid | output | 1 | Current half period carries an active pixel |
| die_idx | output | DIE_W | Die index of the current pixel |
| pix_idx | output | PIX_W | Pixel index within its die |
| line_done | output | 1 | One-cycle pulse on the last cycle of a line |
| clamp_flag | output | 1 | Sticky: some line period was extended to the minimum |

## Verification
A wrong half-period count shows up in the sensor clock within one half period. Because every later output is timed from that count, all of them slide out of step for the rest of the line. A pixel or die counter that is off by one corrupts the indices at the first active pixel or the first die boundary, and the valid window ends early or late at the end of the active region. A wrong minimum-length calculation, or a latch taken at the wrong time, first shows at the end of the affected line: line-done arrives in the wrong cycle and the next start pulse moves with it. The bench compares every output in every system cycle against an arithmetic model. Each of these faults is therefore caught on the cycle it first becomes visible.

// File: rtl/cis_seq_pkg.sv
package cis_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Rounded-up integer division for parameter derivation.
    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Fewest sensor cycles that carry the whole stream at two pixels per cycle.
    function automatic int unsigned line_min_clocks(input int unsigned lead,
                                                    input int unsigned act,
                                                    input int unsigned dies);
        return (lead + act * dies + 1) / 2;
    endfunction

endpackage

// File: rtl/cis_half_timer.sv
module cis_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cis_line_ctrl.sv
module cis_line_ctrl
    import cis_seq_pkg::*;
#(
    parameter int INACTIVE = 55,
    parameter int ACT_FULL = 688,
    parameter int MAX_DIES = 8,
    parameter int DIV_W    = 8,
    parameter int PER_W    = 16,
    parameter int HALF_MIN = 17,
    parameter int HALF_MAX = 100,
    parameter int DIE_W    = 4,
    parameter int ACT_W    = 10,
    parameter int CLK_W    = 16,
    parameter int HC_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode_full,
    input  logic [DIE_W-1:0] die_count,
    input  logic [DIV_W-1:0] half_div,
    input  logic [PER_W-1:0] line_period,
    input  logic             tick,
    output logic             running,
    output logic             line_start,
    output logic             line_done,
    output logic [HC_W-1:0]  hcnt,
    output logic             mode_q,
    output logic [DIE_W-1:0] dies_q,
    output logic [ACT_W-1:0] act_q,
    output logic [DIV_W-1:0] half_q,
    output logic             clamp_flag
);
    seq_state_e       state_q;
    logic [HC_W-1:0]  hcnt_q, last_q;
    logic             clamp_q;

    logic [DIE_W-1:0] dies_c;
    logic [ACT_W-1:0] act_c;
    logic [DIV_W-1:0] half_c;
    logic [CLK_W-1:0] min_c, per_c, eff_c;
    logic [HC_W-1:0]  last_c;
    logic             short_c;

    // Settings as they would be latched if a line started in this cycle.
    always_comb begin
        if (die_count == '0) begin
            dies_c = DIE_W'(1);
        end else if (die_count > DIE_W'(MAX_DIES)) begin
            dies_c = DIE_W'(MAX_DIES);
        end else begin
            dies_c = die_count;
        end

        act_c = mode_full ? ACT_W'(ACT_FULL) : ACT_W'(ACT_FULL / 2);

        if (half_div < DIV_W'(HALF_MIN)) begin
            half_c = DIV_W'(HALF_MIN);
        end else if (half_div > DIV_W'(HALF_MAX)) begin
            half_c = DIV_W'(HALF_MAX);
        end else begin
            half_c = half_div;
        end

        min_c   = CLK_W'(line_min_clocks(INACTIVE, 32'(act_c), 32'(dies_c)));
        per_c   = CLK_W'(line_period);
        short_c = per_c < min_c;
        eff_c   = short_c ? min_c : per_c;
        last_c  = {eff_c, 1'b0} - HC_W'(1);
    end

    assign running    = (state_q == SEQ_RUN);
    assign line_done  = running && tick && (hcnt_q == last_q);
    assign line_start = en && (!running || line_done);
    assign hcnt       = hcnt_q;
    assign clamp_flag = clamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            hcnt_q  <= '0;
            last_q  <= HC_W'(1);
            mode_q  <= 1'b0;
            dies_q  <= DIE_W'(1);
            act_q   <= ACT_W'(ACT_FULL / 2);
            half_q  <= DIV_W'(HALF_MIN);
            clamp_q <= 1'b0;
        end else if (line_start) begin
            state_q <= SEQ_RUN;
            hcnt_q  <= '0;
            last_q  <= last_c;
            mode_q  <= mode_full;
            dies_q  <= dies_c;
            act_q   <= act_c;
            half_q  <= half_c;
            clamp_q <= clamp_q | short_c;
        end else if (line_done) begin
            state_q <= SEQ_IDLE;
            hcnt_q  <= '0;
        end else if (running && tick) begin
            hcnt_q  <= hcnt_q + HC_W'(1);
        end
    end
endmodule

// File: rtl/cis_pix_track.sv
module cis_pix_track #(
    parameter int INACTIVE = 55,
    parameter int DIE_W    = 4,
    parameter int ACT_W    = 10,
    parameter int PIX_W    = 10,
    parameter int HC_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             restart,
    input  logic             tick,
    input  logic [HC_W-1:0]  hcnt,
    input  logic [ACT_W-1:0] act,
    input  logic [DIE_W-1:0] dies,
    output logic             valid,
    output logic [DIE_W-1:0] die_idx,
    output logic [PIX_W-1:0] pix_idx
);
    logic [PIX_W-1:0] pix_q;
    logic [DIE_W-1:0] die_q;
    logic             in_active;

    assign in_active = (hcnt >= HC_W'(INACTIVE)) && (die_q < dies);
    assign valid     = running && in_active;
    assign die_idx   = valid ? die_q : '0;
    assign pix_idx   = valid ? pix_q : '0;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pix_q <= '0;
            die_q <= '0;
        end else if (running && tick && in_active) begin
            if (ACT_W'(pix_q) + ACT_W'(1) == act) begin
                pix_q <= '0;
                die_q <= die_q + DIE_W'(1);
            end else begin
                pix_q <= pix_q + PIX_W'(1);
            end
        end
    end
endmodule

// File: rtl/cis_readout_seq.sv
module cis_readout_seq
    import cis_seq_pkg::*;
#(
    parameter int SYS_HZ     = 50_000_000,
    parameter int PIX_MIN_HZ = 500_000,
    parameter int PIX_MAX_HZ = 3_000_000,
    parameter int INACTIVE   = 55,
    parameter int ACT_FULL   = 688,
    parameter int MAX_DIES   = 8,
    parameter int DIV_W      = 8,
    parameter int PER_W      = 16,
    localparam int DIE_W     = $clog2(MAX_DIES + 1),
    localparam int PIX_W     = $clog2(ACT_FULL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode_full,
    input  logic [DIE_W-1:0] die_count,
    input  logic [DIV_W-1:0] half_div,
    input  logic [PER_W-1:0] line_period,
    output logic             sensor_start,
    output logic             sensor_clk,
    output logic             mode_pin,
    output logic             pix_valid,
    output logic [DIE_W-1:0] die_idx,
    output logic [PIX_W-1:0] pix_idx,
    output logic             line_done,
    output logic             clamp_flag
);
    localparam int HALF_MIN = int'(div_ceil(SYS_HZ, PIX_MAX_HZ));
    localparam int HALF_MAX = SYS_HZ / PIX_MIN_HZ;
    localparam int ACT_W    = $clog2(ACT_FULL + 1);
    localparam int MAXCLK   = int'(line_min_clocks(INACTIVE, ACT_FULL, MAX_DIES));
    localparam int MCLK_W   = $clog2(MAXCLK + 1);
    localparam int CLK_W    = (PER_W > MCLK_W) ? PER_W : MCLK_W;
    localparam int HC_W     = CLK_W + 1;

    logic             running, line_start, tick;
    logic [HC_W-1:0]  hcnt;
    logic [DIE_W-1:0] dies_q;
    logic [ACT_W-1:0] act_q;
    logic [DIV_W-1:0] half_q;

    cis_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .half (half_q),
        .tick (tick)
    );

    cis_line_ctrl #(
        .INACTIVE (INACTIVE), .ACT_FULL (ACT_FULL), .MAX_DIES (MAX_DIES),
        .DIV_W    (DIV_W),    .PER_W    (PER_W),
        .HALF_MIN (HALF_MIN), .HALF_MAX (HALF_MAX),
        .DIE_W    (DIE_W),    .ACT_W    (ACT_W),
        .CLK_W    (CLK_W),    .HC_W     (HC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .mode_full   (mode_full),
        .die_count   (die_count),
        .half_div    (half_div),
        .line_period (line_period),
        .tick        (tick),
        .running     (running),
        .line_start  (line_start),
        .line_done   (line_done),
        .hcnt        (hcnt),
        .mode_q      (mode_pin),
        .dies_q      (dies_q),
        .act_q       (act_q),
        .half_q      (half_q),
        .clamp_flag  (clamp_flag)
    );

    cis_pix_track #(
        .INACTIVE (INACTIVE), .DIE_W (DIE_W), .ACT_W (ACT_W),
        .PIX_W    (PIX_W),    .HC_W  (HC_W)
    ) u_pix (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .restart (line_start),
        .tick    (tick),
        .hcnt    (hcnt),
        .act     (act_q),
        .dies    (dies_q),
        .valid   (pix_valid),
        .die_idx (die_idx),
        .pix_idx (pix_idx)
    );

    // Low half first, high half second: the rising edge sits mid-cycle.
    assign sensor_clk   = running && hcnt[0];
    assign sensor_start = running && (hcnt < HC_W'(2));
endmodule

// File: rtl/cis_readout_seq_chk.sv
module cis_readout_seq_chk #(
    parameter int ACT_FULL = 688,
    parameter int PIX_W    = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             sensor_start,
    input logic             sensor_clk,
    input logic             mode_pin,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_idx,
    input logic             line_done,
    input logic             clamp_flag
);
    // R3
    start_mid_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sensor_start) |-> !sensor_clk);

    // R5
    pix_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (32'(pix_idx) < (mode_pin ? ACT_FULL : ACT_FULL / 2)));

    // R9
    next_line_chk: assert property (@(posedge clk) disable iff (rst)
        (line_done && en) |=> sensor_start);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);

    // R10
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_pin) |-> sensor_start);

    // R8
    clamp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        clamp_flag |=> clamp_flag);
endmodule

bind cis_readout_seq cis_readout_seq_chk #(
    .ACT_FULL (ACT_FULL),
    .PIX_W    (PIX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .sensor_start (sensor_start),
    .sensor_clk   (sensor_clk),
    .mode_pin     (mode_pin),
    .pix_valid    (pix_valid),
    .pix_idx      (pix_idx),
    .line_done    (line_done),
    .clamp_flag   (clamp_flag)
);

// File: tb/cis_readout_seq_bench.sv
module cis_readout_seq_bench;
    localparam int SYS  = 6_000_000;
    localparam int INA  = 5;
    localparam int ACTF = 6;
    localparam int MAXD = 2;
    localparam int DW   = 4;
    localparam int PW   = 5;
    localparam int HMIN = 2;
    localparam int HMAX = 12;
    localparam int DIEW = 2;
    localparam int PIXW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic mode_full = 1'b1;
    logic [DIEW-1:0] die_count = 2'd2;
    logic [DW-1:0]   half_div = 4'd3;
    logic [PW-1:0]   line_period = 5'd20;
    logic sensor_start, sensor_clk, mode_pin, pix_valid, line_done, clamp_flag;
    logic [DIEW-1:0] die_idx;
    logic [PIXW-1:0] pix_idx;

    always #10 clk = ~clk;

    cis_readout_seq #(
        .SYS_HZ (SYS), .INACTIVE (INA), .ACT_FULL (ACTF), .MAX_DIES (MAXD),
        .DIV_W (DW), .PER_W (PW)
    ) u_cis_readout_seq (
        .clk (clk), .rst (rst), .en (en), .mode_full (mode_full),
        .die_count (die_count), .half_div (half_div), .line_period (line_period),
        .sensor_start (sensor_start), .sensor_clk (sensor_clk), .mode_pin (mode_pin),
        .pix_valid (pix_valid), .die_idx (die_idx), .pix_idx (pix_idx),
        .line_done (line_done), .clamp_flag (clamp_flag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string phase = "reset";

    // Model state: line timing taken from the inputs at each line start.
    bit m_run = 1'b0, m_mode = 1'b0, m_clamp = 1'b0;
    int t = 0, c_half = HMIN, c_act = ACTF / 2, c_dies = 1, c_len = 2;

    task automatic chk(input string tag, input string nm, input int a, input int e);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s (%s) %s: got %0d expected %0d", tag, phase, nm, a, e);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic latch();
        int mn, eff;
        c_half = clampi(int'(half_div), HMIN, HMAX);           // R2
        c_dies = clampi(int'(die_count), 1, MAXD);             // R6
        c_act  = mode_full ? ACTF : ACTF / 2;                  // R4
        mn     = (INA + c_act * c_dies + 1) / 2;               // R7
        eff    = (int'(line_period) < mn) ? mn : int'(line_period);
        if (int'(line_period) < mn) m_clamp = 1'b1;            // R8
        m_mode = mode_full;
        c_len  = 2 * eff * c_half;
    endtask

    // Model the coming rising edge, then compare all outputs at the falling edge.
    task automatic adv();
        int h, e_valid, e_die, e_pix;
        if (m_run) begin
            if (t == c_len - 1) begin
                if (en) begin t = 0; latch(); end       // R9 R10
                else begin m_run = 1'b0; t = 0; end     // R11
            end else begin
                t++;
            end
        end else if (en) begin
            m_run = 1'b1; t = 0; latch();               // R11
        end
        @(negedge clk);
        h = t / c_half;
        e_valid = (m_run && h >= INA && h < INA + c_act * c_dies) ? 1 : 0;
        e_die = e_valid ? (h - INA) / c_act : 0;
        e_pix = e_valid ? (h - INA) % c_act : 0;
        chk("R1", "sensor_clk", int'(sensor_clk), m_run ? (h % 2) : 0);
        chk("R3", "sensor_start", int'(sensor_start), (m_run && h < 2) ? 1 : 0);
        chk("R4", "mode_pin", int'(mode_pin), int'(m_mode));
        chk("R5", "pix_valid", int'(pix_valid), e_valid);
        chk("R6", "die_idx", int'(die_idx), e_die);
        chk("R5", "pix_idx", int'(pix_idx), e_pix);
        chk("R7,R9", "line_done", int'(line_done), (m_run && t == c_len - 1) ? 1 : 0);
        chk("R8", "clamp_flag", int'(clamp_flag), int'(m_clamp));
    endtask

    task automatic wait_mid();
        while (!(m_run && t == 3)) adv();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R4", "reset mode_pin", int'(mode_pin), 0);
        chk("R8", "reset clamp_flag", int'(clamp_flag), 0);
        chk("R3", "reset sensor_start", int'(sensor_start), 0);
        rst = 1'b0;
        phase = "idle after reset";
        repeat (4) adv();

        // Two lines with a period well above the minimum: no clamp.
        phase = "R11 first start";
        en = 1'b1;
        wait_mid();
        adv();
        wait_mid();

        // R2 R6 R7 R10: every setting changes mid-line and applies to the next line.
        phase = "R2 R6 R7 R10 sweep";
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 4; d++) begin
                for (int v = 0; v < 4; v++) begin
                    for (int p = 0; p < 3; p++) begin
                        wait_mid();
                        mode_full   = m[0];
                        die_count   = DIEW'(d);
                        half_div    = (v == 0) ? 4'd0 : (v == 1) ? 4'd2 : (v == 2) ? 4'd7 : 4'd15;
                        line_period = (p == 0) ? 5'd0 : (p == 1) ? 5'd9 : 5'd20;
                        adv();
                    end
                end
            end
        end

        // R11: drop enable mid-line, the line finishes and the block idles.
        wait_mid();
        phase = "R11 disable";
        en = 1'b0;
        while (m_run) adv();
        repeat (10) adv();

        // R11: restart from idle with new settings.
        phase = "R11 restart";
        mode_full = 1'b0; die_count = 2'd1; half_div = 4'd2; line_period = 5'd0;
        en = 1'b1;
        adv();
        wait_mid();
        en = 1'b0;
        while (m_run) adv();
        repeat (4) adv();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (%s): got hung expected finished", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule